// File: doc/BRIEF.md
# Bidirectional General-Purpose Pin Port

This block gives a processor control over a row of general-purpose pins through four word registers on a simple memory bus. A two-bit register select and a write strobe reach the block after address decoding, and the read data is a combinational function of the select. Each pin is set to input or output on its own. An output pin is driven from a stored output latch through a per-pin driver enable. An input pin is left undriven and is sampled from the outside world.

The input pins pass through a two-flop synchronizer. A rising transition on a synchronized input is caught in a sticky capture bit. Software clears that bit by writing 1 to its position. The capture bits are ANDed with an interrupt mask, and the result is reduced to one interrupt request line.

Each capture bit is a small two-state machine. `EDGE_IDLE` moves to `EDGE_HELD` on a detected rise (transition *catch*). `EDGE_HELD` moves back to `EDGE_IDLE` on a write-1 clear with no rise in the same cycle (transition *release*). In every other case the state holds.

Register select encoding: 0 = pin data (word offset +0), 1 = direction (+4), 2 = interrupt mask (+8), 3 = edge capture (+12).

Top module: `gpio_port`

## Requirements
- R1: After reset, the direction, output latch, mask and edge capture registers are all zero. Every driver enable is 0 and the interrupt line is 0.
- R2: Writing the direction register (select 1) sets `pin_oe` to the written value from the next clock edge, and the register reads back that value. A bit of 1 makes the pin an output and a bit of 0 leaves it undriven.
- R3: Writing the data register (select 0) loads the output latch, and `pin_out` shows it. Reading select 0 returns the latch value for each pin whose direction bit is 1.
- R4: Reading select 0 returns the level of `pin_in` for each pin whose direction bit is 0. The level is seen two clock edges after it is applied.
- R5: Writing a data bit for a pin configured as an input changes neither that pin's `pin_oe` nor its readback in the data register.
- R6: A 0-to-1 transition on a synchronized input sets that pin's edge bit (select 3) on the third clock edge after the pin changes. The bit then stays at 1 after the pin returns to 0.
- R7: Writing 1 to an edge bit clears it. Writing 0 to an edge bit leaves it unchanged.
- R8: When a new rise and a write-1 clear hit the same edge bit in the same cycle, the bit stays set.
- R9: `irq` is 1 exactly when some bit is set in both the edge register and the mask register (select 2). The mask reads back as written.
- R10: A 1-to-0 transition on an input does not set its edge bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select: 0 data, 1 direction, 2 mask, 3 edge |
| wr_en | input | 1 | Write strobe for the selected register |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Read data of the selected register |
| pin_in | input | 32 | Level seen at each pin |
| pin_out | output | 32 | Output latch value per pin |
| pin_oe | output | 32 | Driver enable per pin (1 = output) |
| irq | output | 1 | Interrupt request |

## Verification
A capture machine stuck in the wrong state shows at the ports as a wrong edge-register readback and a wrong `irq` level. A missed catch appears on the third edge after the pin rises. A missed release appears one edge after the clearing write. A corrupted direction or output latch shows on `pin_oe`, `pin_out` and the data readback on the edge right after the write. A synchronizer fault shifts the input readback away from its two-edge latency, and the bench checks that latency directly.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
    // Register select codes; word offset = code * 4
    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_DIR  = 2'd1,
        REG_MASK = 2'd2,
        REG_EDGE = 2'd3
    } gpio_reg_e;

    typedef enum logic {
        EDGE_IDLE = 1'b0,
        EDGE_HELD = 1'b1
    } edge_state_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    logic [WIDTH-1:0] stage1_q;
    logic [WIDTH-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= din;
            stage2_q <= stage1_q;
        end
    end

    assign dout = stage2_q;

    // Checker: two-edge latency once two edges have passed since reset
    logic [1:0] warm_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              warm_q <= 2'd0;
        else if (warm_q != 2'd2) warm_q <= warm_q + 2'd1;
    end

    assert_sync_latency_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (warm_q == 2'd2) |-> (dout == $past(din, 2)));
endmodule

// File: rtl/gpio_edge_cell.sv
module gpio_edge_cell
    import gpio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rise,
    input  logic clr,
    output logic captured
);
    edge_state_e state_q;
    edge_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= EDGE_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EDGE_IDLE: if (rise)          state_d = EDGE_HELD;
            EDGE_HELD: if (clr && !rise)  state_d = EDGE_IDLE;
        endcase
    end

    always_comb begin
        captured = (state_q == EDGE_HELD);
    end

    assert_catch_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> captured);
    assert_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (captured && !clr) |=> captured);
    assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !rise) |=> !captured);
    assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && rise) |=> captured);
    assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!captured && !rise) |=> !captured);
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_pkg::*;
#(
    parameter int PIN_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       reg_sel,
    input  logic             wr_en,
    input  logic [PIN_W-1:0] wr_data,
    output logic [PIN_W-1:0] rd_data,
    input  logic [PIN_W-1:0] pin_in,
    output logic [PIN_W-1:0] pin_out,
    output logic [PIN_W-1:0] pin_oe,
    output logic             irq
);
    gpio_reg_e        sel;
    logic [PIN_W-1:0] dir_q;
    logic [PIN_W-1:0] latch_q;
    logic [PIN_W-1:0] mask_q;
    logic [PIN_W-1:0] sync_lvl;
    logic [PIN_W-1:0] prev_q;
    logic [PIN_W-1:0] rise;
    logic [PIN_W-1:0] edge_clr;
    logic [PIN_W-1:0] edge_bits;
    logic [PIN_W-1:0] pin_level;

    assign sel = gpio_reg_e'(reg_sel);

    // Register file writes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q   <= '0;
            latch_q <= '0;
            mask_q  <= '0;
        end else if (wr_en) begin
            unique case (sel)
                REG_DATA: latch_q <= wr_data;
                REG_DIR:  dir_q   <= wr_data;
                REG_MASK: mask_q  <= wr_data;
                REG_EDGE: ;
            endcase
        end
    end

    gpio_sync #(.WIDTH(PIN_W)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (pin_in),
        .dout  (sync_lvl)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= sync_lvl;
    end

    assign rise     = sync_lvl & ~prev_q;
    assign edge_clr = (wr_en && sel == REG_EDGE) ? wr_data : '0;

    for (genvar i = 0; i < PIN_W; i++) begin : g_edge
        gpio_edge_cell i_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .rise     (rise[i]),
            .clr      (edge_clr[i]),
            .captured (edge_bits[i])
        );
    end

    // Pin level: own latch for outputs, synchronized input otherwise
    assign pin_level = (dir_q & latch_q) | (~dir_q & sync_lvl);

    always_comb begin
        unique case (sel)
            REG_DATA: rd_data = pin_level;
            REG_DIR:  rd_data = dir_q;
            REG_MASK: rd_data = mask_q;
            REG_EDGE: rd_data = edge_bits;
        endcase
    end

    assign pin_out = latch_q;
    assign pin_oe  = dir_q;
    assign irq     = |(edge_bits & mask_q);

    assert_oe_after_dir_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == REG_DIR) |=> (pin_oe == $past(wr_data)));
    assert_out_after_data_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == REG_DATA) |=> (pin_out == $past(wr_data)));
    assert_oe_stable_on_data_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == REG_DATA) |=> $stable(pin_oe));
    assert_mask_zero_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && sel == REG_MASK && wr_data == '0) |=> !irq);
endmodule

// File: tb/test_gpio_port.sv
module test_gpio_port;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  reg_sel = 2'd0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic [31:0] pin_in = '0;
    logic [31:0] pin_out;
    logic [31:0] pin_oe;
    logic        irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    gpio_port i_gpio_port (
        .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en),
        .wr_data(wr_data), .rd_data(rd_data), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Called at a negedge; returns at the next negedge
    task automatic bus_write(input logic [1:0] s, input logic [31:0] d);
        reg_sel = s; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic bus_read(input logic [1:0] s, output logic [31:0] d);
        reg_sel = s;
        #1 d = rd_data;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int s = 0; s < 4; s++) begin
            if (s == 0) continue;
            bus_read(s[1:0], v);
            chk("R1 reset register", v, 32'h0);
        end
        chk("R1 reset pin_oe", pin_oe, 32'h0);
        chk("R1 reset pin_out", pin_out, 32'h0);
        chk("R1 reset irq", {31'h0, irq}, 32'h0);
    endtask

    task automatic t_direction_and_output();
        logic [31:0] v;
        bus_write(2'd1, 32'h0000_FFFF);
        chk("R2 pin_oe", pin_oe, 32'h0000_FFFF);
        bus_read(2'd1, v);
        chk("R2 direction readback", v, 32'h0000_FFFF);
        pin_in = 32'hFFFF_0000;
        bus_write(2'd0, 32'hA5A5_1234);
        chk("R3 pin_out", pin_out, 32'hA5A5_1234);
        cycles(2);
        bus_read(2'd0, v);
        chk("R3 R4 mixed readback", v, 32'hFFFF_1234);
    endtask

    task automatic t_input_latency();
        logic [31:0] v;
        pin_in = 32'h00F0_0000;
        @(negedge clk);
        bus_read(2'd0, v);
        chk("R4 not yet visible after one edge", v & 32'hFFFF_0000, 32'hFFFF_0000);
        @(negedge clk);
        bus_read(2'd0, v);
        chk("R4 visible after two edges", v & 32'hFFFF_0000, 32'h00F0_0000);
    endtask

    task automatic t_input_write_ignored();
        logic [31:0] v;
        pin_in = 32'h0;
        cycles(3);
        bus_write(2'd0, 32'hFFFF_0000);
        chk("R5 pin_oe unchanged", pin_oe, 32'h0000_FFFF);
        bus_read(2'd0, v);
        chk("R5 input readback unchanged", v & 32'hFFFF_0000, 32'h0);
    endtask

    task automatic t_edge_capture();
        logic [31:0] v;
        bus_write(2'd3, 32'hFFFF_FFFF);
        pin_in = 32'h0000_0005;
        cycles(2);
        bus_read(2'd3, v);
        chk("R6 not set before third edge", v, 32'h0);
        cycles(1);
        bus_read(2'd3, v);
        chk("R6 set on third edge", v, 32'h0000_0005);
        pin_in = 32'h0;
        cycles(4);
        bus_read(2'd3, v);
        chk("R6 R10 sticky after fall", v, 32'h0000_0005);
        bus_write(2'd3, 32'h0);
        bus_read(2'd3, v);
        chk("R7 write 0 keeps", v, 32'h0000_0005);
        bus_write(2'd3, 32'h0000_0004);
        bus_read(2'd3, v);
        chk("R7 write 1 clears", v, 32'h0000_0001);
    endtask

    task automatic t_falling_only();
        logic [31:0] v;
        bus_write(2'd3, 32'hFFFF_FFFF);
        pin_in = 32'h0000_0100;
        cycles(4);
        bus_write(2'd3, 32'h0000_0100);
        pin_in = 32'h0;
        cycles(4);
        bus_read(2'd3, v);
        chk("R10 fall does not set", v, 32'h0);
    endtask

    task automatic t_set_wins();
        logic [31:0] v;
        pin_in = 32'h0000_0003;
        cycles(4);
        pin_in = 32'h0000_0002;
        cycles(4);
        pin_in = 32'h0000_0003;
        cycles(2);
        // rise on bit 0 is active at the next edge together with the clear
        bus_write(2'd3, 32'h0000_0003);
        bus_read(2'd3, v);
        chk("R8 set wins, R7 bit1 cleared", v, 32'h0000_0001);
        pin_in = 32'h0;
        cycles(3);
    endtask

    task automatic t_irq();
        logic [31:0] v;
        chk("R9 irq low with mask zero", {31'h0, irq}, 32'h0);
        bus_write(2'd2, 32'h0000_0002);
        bus_read(2'd2, v);
        chk("R9 mask readback", v, 32'h0000_0002);
        chk("R9 irq low when masked off", {31'h0, irq}, 32'h0);
        bus_write(2'd2, 32'h8000_0001);
        chk("R9 irq high", {31'h0, irq}, 32'h1);
        bus_write(2'd3, 32'h0000_0001);
        chk("R9 irq low after clear", {31'h0, irq}, 32'h0);
    endtask

    initial begin
        #(20 * 200000);
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        cycles(2);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_direction_and_output();
        t_input_latency();
        t_input_write_ignored();
        t_edge_capture();
        t_falling_only();
        t_set_wins();
        t_irq();
        cycles(2);
        finish_run();
    end
endmodule